// File: doc/BRIEF.md
# Burst-Count PWM Generator with Interrupt

A memory-mapped pulse-width modulation peripheral that drives one output line toward a GPIO pin. Software programs a period and a high-time (duty), both counted in clock cycles, and sets a global enable bit. While it runs, the output is high for the first `duty` cycles of every period and low for the rest. The effective duty cycle is duty divided by period, so a period of 8 with a duty of 4 gives a 50 % square wave.

A wave-count register bounds the run. A non-zero value N stops the output after exactly N complete periods, even though the enable bit stays set. Zero lets the generator run until software clears the enable. Completing a finite burst sets a done status bit and a pending interrupt flag. The flag reaches the interrupt request line only when interrupts are enabled and the source is unmasked. Software removes it with a write-one clear. Period and duty changes wait for the next period boundary, so a wave in progress is never cut short.

Top module: `pwm_burst_gen`

## Requirements
- R1: After reset `pwm_out` and `irq_req` are low and every register reads 0.
- R2: While running, in each period of P cycles (a period value of 0 acts as 1) the output is high for the first D cycles and low for the remaining P-D. The first high cycle is the cycle right after the edge that accepts the enabling write.
- R3: A duty of 0 holds the output low for the whole period, and a duty equal to or above the period holds it high.
- R4: Writing 0 to control bit 0 (the enable) forces the output low from the next cycle and resets the phase and wave counters. After a later re-enable the output restarts at phase 0.
- R5: With a non-zero count N the output produces exactly N complete waves, then stays low while the enable remains set, and status bit 1 (done) reads 1.
- R6: With a count of 0 the output repeats waves without end, and done stays 0.
- R7: Period and duty values written during a wave do not alter that wave. They take effect from the next period boundary.
- R8: Status bit 0 (pending) is set when a finite burst completes. `irq_req` is high exactly when pending is set, bit 0 of the interrupt-enable register is 1 and bit 0 of the interrupt-mask register is 0.
- R9: Writing 1 to bit 0 of the clear register resets pending, and the clear register reads 0. If a clear lands in the same cycle as a burst completion, pending ends up set.
- R10: A 0-to-1 write of the enable bit clears done and restarts the wave count from zero. Writing 1 while the enable is already 1 changes nothing, so a finished burst stays finished.
- R11: Register map at byte offsets: 0x00 control (bit 0), 0x04 period, 0x08 duty, 0x0C count (all full width), 0x10 interrupt enable (bit 0), 0x14 interrupt mask (bit 0), 0x18 clear, 0x1C status. Unused bits read 0. Writes need `bus_cs` and `bus_we` together. Reads are combinational while `bus_cs` is high and `bus_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by `bus_cs` |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when not reading |
| pwm_out | output | 1 | Waveform toward a GPIO pin |
| irq_req | output | 1 | Interrupt request toward the interrupt controller |

## Verification
Two functions can fall in the same cycle: the final wave of a burst setting the pending flag, and a software clear write removing it. The bench provokes this by counting edges from the enabling write and issuing the clear so that it is accepted on the same edge that ends the last of three five-cycle waves. Status then has to show pending set. A second overlap is a period/duty rewrite accepted inside a running wave, judged cycle by cycle against the old shape for that wave and the new shape afterwards.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;

  // byte offsets of the registers
  localparam int OFS_CTRL   = 'h00;
  localparam int OFS_PERIOD = 'h04;
  localparam int OFS_DUTY   = 'h08;
  localparam int OFS_COUNT  = 'h0C;
  localparam int OFS_IEN    = 'h10;
  localparam int OFS_IMASK  = 'h14;
  localparam int OFS_ICLR   = 'h18;
  localparam int OFS_STATUS = 'h1C;

  // bit positions
  localparam int CTRL_EN_BIT  = 0;
  localparam int ICLR_BIT     = 0;
  localparam int STAT_PEND_BIT = 0;
  localparam int STAT_DONE_BIT = 1;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_PERIOD,
    SEL_DUTY,
    SEL_COUNT,
    SEL_IEN,
    SEL_IMASK,
    SEL_ICLR,
    SEL_STATUS
  } reg_sel_e;

endpackage

// File: rtl/pwm_burst_regs.sv
module pwm_burst_regs
  import pwm_burst_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  parameter int PW     = 32,
  parameter int CW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              pend_i,
  input  logic              done_i,
  output logic              en_o,
  output logic              start_o,
  output logic              clr_o,
  output logic [PW-1:0]     period_o,
  output logic [PW-1:0]     duty_o,
  output logic [CW-1:0]     count_o,
  output logic              ien_o,
  output logic              imask_o
);

  function automatic reg_sel_e decode(input logic [ADDR_W-1:0] a);
    case (32'(a))
      OFS_CTRL:   return SEL_CTRL;
      OFS_PERIOD: return SEL_PERIOD;
      OFS_DUTY:   return SEL_DUTY;
      OFS_COUNT:  return SEL_COUNT;
      OFS_IEN:    return SEL_IEN;
      OFS_IMASK:  return SEL_IMASK;
      OFS_ICLR:   return SEL_ICLR;
      OFS_STATUS: return SEL_STATUS;
      default:    return SEL_NONE;
    endcase
  endfunction

  reg_sel_e sel;
  logic     wr_evt;
  logic     rd_evt;
  logic     en_q;
  logic [PW-1:0] period_q;
  logic [PW-1:0] duty_q;
  logic [CW-1:0] count_q;
  logic     ien_q;
  logic     imask_q;

  assign sel    = decode(addr_i);
  assign wr_evt = cs_i && we_i;
  assign rd_evt = cs_i && !we_i;

  // enabling edge: a one written while the enable is clear
  assign start_o = wr_evt && (sel == SEL_CTRL) && wdata_i[CTRL_EN_BIT] && !en_q;
  assign clr_o   = wr_evt && (sel == SEL_ICLR) && wdata_i[ICLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      period_q <= '0;
      duty_q   <= '0;
      count_q  <= '0;
      ien_q    <= 1'b0;
      imask_q  <= 1'b0;
    end else if (wr_evt) begin
      case (sel)
        SEL_CTRL:   en_q     <= wdata_i[CTRL_EN_BIT];
        SEL_PERIOD: period_q <= wdata_i[PW-1:0];
        SEL_DUTY:   duty_q   <= wdata_i[PW-1:0];
        SEL_COUNT:  count_q  <= wdata_i[CW-1:0];
        SEL_IEN:    ien_q    <= wdata_i[0];
        SEL_IMASK:  imask_q  <= wdata_i[0];
        default:    ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_evt) begin
      case (sel)
        SEL_CTRL:   rdata_o[CTRL_EN_BIT] = en_q;
        SEL_PERIOD: rdata_o = DW'(period_q);
        SEL_DUTY:   rdata_o = DW'(duty_q);
        SEL_COUNT:  rdata_o = DW'(count_q);
        SEL_IEN:    rdata_o[0] = ien_q;
        SEL_IMASK:  rdata_o[0] = imask_q;
        SEL_STATUS: begin
          rdata_o[STAT_PEND_BIT] = pend_i;
          rdata_o[STAT_DONE_BIT] = done_i;
        end
        default:    rdata_o = '0;
      endcase
    end
  end

  assign en_o     = en_q;
  assign period_o = period_q;
  assign duty_o   = duty_q;
  assign count_o  = count_q;
  assign ien_o    = ien_q;
  assign imask_o  = imask_q;

  // R10
  start_sets_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> en_q);

  // R11
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_i |-> (rdata_o == '0));

endmodule

// File: rtl/pwm_wave_core.sv
module pwm_wave_core #(
  parameter int PW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          start_i,
  input  logic [PW-1:0] period_i,
  input  logic [PW-1:0] duty_i,
  input  logic [CW-1:0] count_i,
  output logic          pwm_o,
  output logic          burst_end_o,
  output logic          done_o
);

  // period of zero behaves as a one-cycle period
  function automatic logic [PW-1:0] eff_period(input logic [PW-1:0] p);
    return (p == '0) ? PW'(1) : p;
  endfunction

  // output level for a given phase
  function automatic logic level_at(input logic [PW-1:0] phase, input logic [PW-1:0] high_time);
    return phase < high_time;
  endfunction

  // true when finishing one more wave reaches the target
  function automatic logic burst_reached(input logic [CW-1:0] waves_done, input logic [CW-1:0] target);
    return (target != '0) && ((waves_done + CW'(1)) >= target);
  endfunction

  logic [PW-1:0] ph_q;
  logic [PW-1:0] per_act_q;
  logic [PW-1:0] duty_act_q;
  logic [CW-1:0] wv_q;
  logic          done_q;
  logic          running;
  logic          wave_end;
  logic          burst_end;

  assign running   = en_i && !done_q;
  assign wave_end  = running && (ph_q == (eff_period(per_act_q) - PW'(1)));
  assign burst_end = wave_end && burst_reached(wv_q, count_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= '0;
      per_act_q  <= '0;
      duty_act_q <= '0;
      wv_q       <= '0;
      done_q     <= 1'b0;
    end else if (start_i) begin
      ph_q       <= '0;
      wv_q       <= '0;
      done_q     <= 1'b0;
      per_act_q  <= period_i;
      duty_act_q <= duty_i;
    end else if (!en_i) begin
      ph_q <= '0;
      wv_q <= '0;
    end else if (wave_end) begin
      ph_q       <= '0;
      wv_q       <= wv_q + CW'(1);
      per_act_q  <= period_i;
      duty_act_q <= duty_i;
      if (burst_end) done_q <= 1'b1;
    end else if (running) begin
      ph_q <= ph_q + PW'(1);
    end
  end

  assign pwm_o       = running && level_at(ph_q, duty_act_q);
  assign burst_end_o = burst_end;
  assign done_o      = done_q;

  // R2
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (ph_q < eff_period(per_act_q)));

  // R4
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !pwm_o);

  // R5
  burst_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && !start_i) |=> (done_q && !pwm_o));

  // R6
  endless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i == '0) |-> !burst_end);

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !wave_end && !start_i) |=> ($stable(per_act_q) && $stable(duty_act_q)));

endmodule

// File: rtl/pwm_irq_ctrl.sv
module pwm_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic ien_i,
  input  logic imask_i,
  output logic pend_o,
  output logic irq_o
);

  logic pend_q;

  // a completion in the same cycle as a clear keeps the flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= 1'b0;
    else if (set_i) pend_q <= 1'b1;
    else if (clr_i) pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q && ien_i && !imask_i;

  // R9
  pend_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_q);

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !pend_q);

  // R8
  irq_masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imask_i || !ien_i) |-> !irq_o);

endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen #(
  parameter int ADDR_W = 5,
  parameter int DW     = 32,
  parameter int PW     = 32,
  parameter int CW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              pwm_out,
  output logic              irq_req
);

  logic          en;
  logic          start;
  logic          clr;
  logic [PW-1:0] period;
  logic [PW-1:0] duty;
  logic [CW-1:0] count;
  logic          ien;
  logic          imask;
  logic          pend;
  logic          done;
  logic          burst_end;

  pwm_burst_regs #(
    .ADDR_W(ADDR_W), .DW(DW), .PW(PW), .CW(CW)
  ) regs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_i     (bus_cs),
    .we_i     (bus_we),
    .addr_i   (bus_addr),
    .wdata_i  (bus_wdata),
    .rdata_o  (bus_rdata),
    .pend_i   (pend),
    .done_i   (done),
    .en_o     (en),
    .start_o  (start),
    .clr_o    (clr),
    .period_o (period),
    .duty_o   (duty),
    .count_o  (count),
    .ien_o    (ien),
    .imask_o  (imask)
  );

  pwm_wave_core #(
    .PW(PW), .CW(CW)
  ) core_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .start_i     (start),
    .period_i    (period),
    .duty_i      (duty),
    .count_i     (count),
    .pwm_o       (pwm_out),
    .burst_end_o (burst_end),
    .done_o      (done)
  );

  pwm_irq_ctrl irq_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (burst_end),
    .clr_i   (clr),
    .ien_i   (ien),
    .imask_i (imask),
    .pend_o  (pend),
    .irq_o   (irq_req)
  );

  // R5
  done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> pend);

endmodule

// File: tb/pwm_burst_gen_tb_top.sv
module pwm_burst_gen_tb_top;

  localparam int A_CTRL = 'h00, A_PER = 'h04, A_DUTY = 'h08, A_CNT = 'h0C;
  localparam int A_IEN = 'h10, A_MASK = 'h14, A_CLR = 'h18, A_STAT = 'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        pwm_out;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  bit    exp_q[$];
  string tag_q[$];
  bit    mon_e;
  string mon_t;

  always #4 clk = ~clk;

  pwm_burst_gen dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq_req(irq_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b1; bus_addr = a[4:0]; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_cs = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_cs = 1'b1; bus_we = 1'b0; bus_addr = a[4:0];
    #1;
    d = bus_rdata;
    bus_cs = 1'b0;
  endtask

  task automatic rd_chk(input int a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  // driver side of the scoreboard: expected output level per cycle
  task automatic push(input bit v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic push_waves(input int p, input int d, input int waves, input string t);
    for (int w = 0; w < waves; w++)
      for (int k = 0; k < p; k++)
        push(k < d, t);
  endtask

  task automatic push_const(input bit v, input int n, input string t);
    for (int i = 0; i < n; i++) push(v, t);
  endtask

  task automatic drain;
    wait (exp_q.size() == 0);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      chk(mon_t, {31'b0, pwm_out}, {31'b0, mon_e});
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 pwm_out in reset", {31'b0, pwm_out}, 0);
    chk("R1 irq_req in reset", {31'b0, irq_req}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk(A_STAT, 0, "R1 status after reset");
    rd_chk(A_PER, 0, "R1 period after reset");
    rd_chk(A_CTRL, 0, "R1 control after reset");

    // R11 register map
    wr(A_PER, 32'd5);
    rd_chk(A_PER, 5, "R11 period readback");
    wr(A_DUTY, 32'd2);
    rd_chk(A_DUTY, 2, "R11 duty readback");
    wr(A_CNT, 32'd3);
    rd_chk(A_CNT, 3, "R11 count readback");
    wr(A_IEN, 32'hFFFF_FFFF);
    rd_chk(A_IEN, 1, "R11 ien single bit");
    wr(A_MASK, 32'h0);
    rd_chk(A_CLR, 0, "R11 clear reads zero");

    // R2 R5 finite burst of 3 waves, period 5 duty 2
    wr(A_CTRL, 1);
    push_waves(5, 2, 3, "R2 R5 burst shape");
    push_const(0, 4, "R5 low after burst");
    drain();
    rd_chk(A_STAT, 3, "R5 R8 status done and pending");

    // R8 interrupt gating
    chk("R8 irq enabled unmasked", {31'b0, irq_req}, 1);
    wr(A_MASK, 1);
    chk("R8 irq masked", {31'b0, irq_req}, 0);
    wr(A_MASK, 0);
    wr(A_IEN, 0);
    chk("R8 irq disabled", {31'b0, irq_req}, 0);
    wr(A_IEN, 1);
    chk("R8 irq reenabled", {31'b0, irq_req}, 1);

    // R9 clear
    wr(A_CLR, 1);
    rd_chk(A_STAT, 2, "R9 pending cleared done kept");
    chk("R9 irq after clear", {31'b0, irq_req}, 0);

    // R10 writing 1 again does nothing
    wr(A_CTRL, 1);
    push_const(0, 5, "R10 no restart on repeated 1");
    drain();
    rd_chk(A_STAT, 2, "R10 done kept on repeated 1");

    // R10 restart via 0 then 1
    wr(A_CTRL, 0);
    wr(A_CTRL, 1);
    push_waves(5, 2, 3, "R10 restarted burst");
    push_const(0, 3, "R10 restarted burst end");
    rd_chk(A_STAT, 0, "R10 done cleared at restart");
    drain();
    rd_chk(A_STAT, 3, "R10 restarted burst completes");
    wr(A_CLR, 1);

    // R9 clear in the completion cycle: pending must survive
    wr(A_CTRL, 0);
    wr(A_CTRL, 1);
    push_waves(5, 2, 3, "R9 collision burst");
    repeat (14) @(posedge clk);
    wr(A_CLR, 1);
    drain();
    rd_chk(A_STAT, 3, "R9 set wins over clear");
    wr(A_CLR, 1);
    rd_chk(A_STAT, 2, "R9 later clear works");

    // R6 endless run
    wr(A_CNT, 0);
    wr(A_CTRL, 0);
    wr(A_CTRL, 1);
    push_waves(5, 2, 8, "R6 endless waves");
    drain();
    rd_chk(A_STAT, 0, "R6 no done in endless mode");

    // R7 shape change mid-wave
    wr(A_CTRL, 0);
    wr(A_PER, 4);
    wr(A_DUTY, 2);
    wr(A_CTRL, 1);
    push_waves(4, 2, 1, "R7 wave in progress kept");
    push_waves(6, 1, 3, "R7 new shape after boundary");
    wr(A_PER, 6);
    wr(A_DUTY, 1);
    drain();

    // R3 duty extremes
    wr(A_CTRL, 0);
    wr(A_PER, 4);
    wr(A_DUTY, 0);
    wr(A_CTRL, 1);
    push_const(0, 10, "R3 duty zero low");
    drain();
    wr(A_CTRL, 0);
    wr(A_DUTY, 4);
    wr(A_CTRL, 1);
    push_const(1, 10, "R3 duty equal period high");
    drain();
    wr(A_CTRL, 0);
    wr(A_DUTY, 9);
    wr(A_CTRL, 1);
    push_const(1, 10, "R3 duty above period high");
    drain();

    // R4 disable mid-wave and restart at phase 0
    wr(A_CTRL, 0);
    wr(A_DUTY, 3);
    wr(A_CTRL, 1);
    push_waves(4, 3, 1, "R4 running before disable");
    drain();
    repeat (1) @(posedge clk);
    wr(A_CTRL, 0);
    push_const(0, 6, "R4 low after disable");
    drain();
    wr(A_CTRL, 1);
    push_waves(4, 3, 2, "R4 restart from phase zero");
    drain();
    chk("R4 irq stays low", {31'b0, irq_req}, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule